// File: doc/BRIEF.md
# Cache Line Fill Controller

This block fetches one four-word cache line from a simple memory bus and hands it to the cache as a single complete line. A fill request names a byte address. The controller asks memory for a burst that starts at the word holding that address and wraps within the line. Memory paces every beat with an acknowledge. If memory refuses the burst by raising the inhibit signal alongside the first beat, the controller fetches the other three words one at a time, in the same wrapped order. The cache cannot tell which path was used.

The request channel is valid/ready. A request is taken on a clock edge where both `req_valid` and `req_ready` are high. `req_ready` is high only while no fill is in progress, so a waiting request stays pending until the block is idle again. The forward port and the line write port have no ready signal. The cache must take each strobe in the cycle it is shown.

The first word to arrive is forwarded to the requester at once. Returned words are collected in a line buffer. In the cycle the fourth word is acknowledged, the whole line is written along with its tag, the valid bit set and every dirty bit clear. A bus error on any beat ends the fill with an error pulse, and no line is written.

Top module: `line_fill_ctrl`

## Requirements
- R1: After reset, and whenever reset is applied in the middle of a fill, `req_ready`=1, `mem_req`=0 and `line_we`=0.
- R2: In the cycle after a request is accepted, `mem_req`=1 and `mem_burst`=1.
- R3: Beat k of a fill is issued at word address (w+k) mod 4, where w is address bits [3:2] of the request. `mem_addr` is {request[31:4], word, 2'b00}, and it stays stable while `mem_req` waits for an acknowledge.
- R4: When `mem_ack` and `mem_inhibit` are both high on the first beat, the remaining three beats are issued with `mem_burst`=0.
- R5: `fwd_valid` pulses once per fill, in the cycle the first beat is acknowledged, with `fwd_data` equal to `mem_rdata` of that beat.
- R6: `line_we` pulses for exactly one cycle, the cycle of the fourth acknowledge. In that cycle `line_data` bits [32i+31:32i] hold the word at offset i, `line_tag`=request[31:10], `line_index`=request[9:4], `line_valid`=1 and `line_dirty`=0. The outputs are identical for the burst path and the inhibited path.
- R7: `mem_err` on any beat pulses `fill_err` in that cycle and writes no line. `mem_req` is low in the next cycle, and the block is ready again.
- R8: `req_ready` is 0 from the cycle after acceptance until the final beat or an error, and a request presented in that time is ignored.
- R9: `mem_inhibit` on the second, third or fourth beat of a burst has no effect: `mem_burst` stays 1.
- R10: `fill_done` pulses in the same cycle as `line_we`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Fill request valid |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_addr | input | 32 | Byte address of the missed access |
| fwd_valid | output | 1 | First-arriving word strobe |
| fwd_data | output | 32 | First-arriving word |
| fill_done | output | 1 | Fill completed successfully |
| fill_err | output | 1 | Fill aborted by bus error |
| mem_req | output | 1 | Memory access request |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_burst | output | 1 | Access is a line burst (1) or single word (0) |
| mem_ack | input | 1 | Beat completed, data valid |
| mem_inhibit | input | 1 | Burst refused (honoured on first beat only) |
| mem_err | input | 1 | Beat failed |
| mem_rdata | input | 32 | Read data |
| line_we | output | 1 | Write complete line into cache arrays |
| line_index | output | 6 | Set index |
| line_tag | output | 22 | Tag to store |
| line_data | output | 128 | Four words, offset order |
| line_valid | output | 1 | Valid bit to store |
| line_dirty | output | 4 | Per-word dirty bits to store |

## Verification
A wrong beat counter or a wrong critical-word register shows on `mem_addr` at the next beat. A missed switch to single reads shows on `mem_burst` at the second beat. A stale or misplaced word in the line buffer shows only at the final `line_we`, where the full 128-bit line is compared against the expected offset order. A state machine stuck busy, or one that returns to idle early, shows within a cycle on `req_ready`, or as a missing or early `fill_done` or `fill_err`.

// File: rtl/lfc_pkg.sv
package lfc_pkg;
  typedef enum logic [1:0] {
    LF_IDLE   = 2'd0,
    LF_BURST  = 2'd1,
    LF_SINGLE = 2'd2
  } lf_state_e;
endpackage

// File: rtl/lfc_seq.sv
module lfc_seq #(
  parameter int WORDS = 4,
  localparam int CW = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] start_word,
  input  logic          mem_ack,
  input  logic          mem_err,
  input  logic          mem_inhibit,
  output logic          busy,
  output logic          mem_req,
  output logic          mem_burst,
  output logic [CW-1:0] cur_word,
  output logic          xfer_ok,
  output logic          xfer_first,
  output logic          xfer_last,
  output logic          abort
);
  import lfc_pkg::*;

  lf_state_e     state_q;
  logic [CW-1:0] beat_q;
  logic [CW-1:0] crit_q;

  assign busy       = (state_q != LF_IDLE);
  assign mem_req    = busy;
  assign mem_burst  = (state_q == LF_BURST);
  assign cur_word   = crit_q + beat_q;
  assign xfer_ok    = busy && mem_ack && !mem_err;
  assign abort      = busy && mem_err;
  assign xfer_first = xfer_ok && (beat_q == '0);
  assign xfer_last  = xfer_ok && (beat_q == CW'(WORDS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= LF_IDLE;
      beat_q  <= '0;
      crit_q  <= '0;
    end else begin
      unique case (state_q)
        LF_IDLE: begin
          if (start) begin
            state_q <= LF_BURST;
            beat_q  <= '0;
            crit_q  <= start_word;
          end
        end
        LF_BURST, LF_SINGLE: begin
          if (abort || xfer_last) begin
            state_q <= LF_IDLE;
            beat_q  <= '0;
          end else if (xfer_ok) begin
            beat_q <= beat_q + 1'b1;
            if (xfer_first && mem_inhibit && state_q == LF_BURST)
              state_q <= LF_SINGLE;
          end
        end
        default: state_q <= LF_IDLE;
      endcase
    end
  end

  AST_START_IS_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> mem_burst); // R2
  AST_ADDR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack && !mem_err) |=> (mem_req && $stable(cur_word))); // R3
  AST_ERR_DROPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !mem_req); // R7
  AST_LATE_INHIBIT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_burst && xfer_ok && !xfer_first && !xfer_last) |=> mem_burst); // R9
endmodule

// File: rtl/lfc_linebuf.sv
module lfc_linebuf #(
  parameter int WORDS  = 4,
  parameter int DATA_W = 32,
  localparam int CW     = $clog2(WORDS),
  localparam int LINE_W = WORDS * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [CW-1:0]     wr_word,
  input  logic [DATA_W-1:0] wr_data,
  output logic [LINE_W-1:0] line
);
  for (genvar i = 0; i < WORDS; i++) begin : g_slot
    logic [DATA_W-1:0] slot_q;
    logic              hit;
    assign hit = wr && (wr_word == CW'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   slot_q <= '0;
      else if (hit) slot_q <= wr_data;
    end

    // bypass so the final word joins the line in its arrival cycle
    assign line[i*DATA_W +: DATA_W] = hit ? wr_data : slot_q;
  end
endmodule

// File: rtl/line_fill_ctrl.sv
module line_fill_ctrl #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int WORDS  = 4,
  parameter int SETS   = 64,
  localparam int OFF_W  = $clog2(DATA_W / 8),
  localparam int CW     = $clog2(WORDS),
  localparam int IDX_W  = $clog2(SETS),
  localparam int TAG_W  = ADDR_W - IDX_W - CW - OFF_W,
  localparam int LINE_W = WORDS * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              fwd_valid,
  output logic [DATA_W-1:0] fwd_data,
  output logic              fill_done,
  output logic              fill_err,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_burst,
  input  logic              mem_ack,
  input  logic              mem_inhibit,
  input  logic              mem_err,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              line_we,
  output logic [IDX_W-1:0]  line_index,
  output logic [TAG_W-1:0]  line_tag,
  output logic [LINE_W-1:0] line_data,
  output logic              line_valid,
  output logic [WORDS-1:0]  line_dirty
);
  logic          busy, start, xfer_ok, xfer_first, xfer_last, abort;
  logic [CW-1:0] cur_word;
  logic [TAG_W-1:0] tag_q;
  logic [IDX_W-1:0] idx_q;

  assign req_ready = !busy;
  assign start     = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_q <= '0;
      idx_q <= '0;
    end else if (start) begin
      tag_q <= req_addr[ADDR_W-1 -: TAG_W];
      idx_q <= req_addr[OFF_W+CW +: IDX_W];
    end
  end

  lfc_seq #(.WORDS(WORDS)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .start_word(req_addr[OFF_W +: CW]),
    .mem_ack(mem_ack), .mem_err(mem_err), .mem_inhibit(mem_inhibit),
    .busy(busy), .mem_req(mem_req), .mem_burst(mem_burst),
    .cur_word(cur_word), .xfer_ok(xfer_ok), .xfer_first(xfer_first),
    .xfer_last(xfer_last), .abort(abort)
  );

  lfc_linebuf #(.WORDS(WORDS), .DATA_W(DATA_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .wr(xfer_ok), .wr_word(cur_word),
    .wr_data(mem_rdata), .line(line_data)
  );

  assign mem_addr   = {tag_q, idx_q, cur_word, {OFF_W{1'b0}}};
  assign fwd_valid  = xfer_first;
  assign fwd_data   = mem_rdata;
  assign line_we    = xfer_last;
  assign fill_done  = xfer_last;
  assign fill_err   = abort;
  assign line_tag   = tag_q;
  assign line_index = idx_q;
  assign line_valid = xfer_last;
  assign line_dirty = '0;

  AST_WRITE_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    line_we |=> !line_we); // R6
  AST_FWD_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |=> !fwd_valid); // R5
  AST_IDLE_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
    (line_we || fill_err) |=> req_ready); // R8
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!req_ready && mem_req)); // R2
endmodule

// File: tb/tb_line_fill_ctrl.sv
`timescale 1ns/1ps
module tb_line_fill_ctrl;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic         rst_n, req_valid, req_ready, fwd_valid, fill_done, fill_err;
  logic [31:0]  req_addr, fwd_data, mem_addr, mem_rdata;
  logic         mem_req, mem_burst, mem_ack, mem_inhibit, mem_err;
  logic         line_we, line_valid;
  logic [5:0]   line_index;
  logic [21:0]  line_tag;
  logic [127:0] line_data;
  logic [3:0]   line_dirty;

  line_fill_ctrl dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .fwd_valid(fwd_valid), .fwd_data(fwd_data),
    .fill_done(fill_done), .fill_err(fill_err), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_burst(mem_burst), .mem_ack(mem_ack),
    .mem_inhibit(mem_inhibit), .mem_err(mem_err), .mem_rdata(mem_rdata),
    .line_we(line_we), .line_index(line_index), .line_tag(line_tag),
    .line_data(line_data), .line_valid(line_valid), .line_dirty(line_dirty)
  );

  int total = 0;
  int bad   = 0;

  typedef struct packed {
    logic [31:0] a;
    logic [1:0]  mode;  // 0 burst, 1 inhibit first beat, 2 inhibit on later beats
    logic [2:0]  eb;    // beat carrying an error, 7 = none
    logic [2:0]  dly;   // wait cycles before each acknowledge
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{32'h0000_1230, 2'd0, 3'd7, 3'd0},
    '{32'h8000_043C, 2'd0, 3'd7, 3'd1},
    '{32'h1234_5678, 2'd1, 3'd7, 3'd0},
    '{32'hFFFF_FFF4, 2'd1, 3'd7, 3'd2},
    '{32'h0000_0004, 2'd2, 3'd7, 3'd0},
    '{32'hABCD_0008, 2'd0, 3'd2, 3'd0},
    '{32'h0F0F_F0F0, 2'd1, 3'd3, 3'd1},
    '{32'h3333_333C, 2'd0, 3'd0, 3'd0}
  };

  function automatic logic [31:0] mdata(input logic [31:0] a);
    return {a[15:0], ~a[31:16]} ^ 32'h5A3C_96E1;
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic run_fill(input logic [31:0] a, input int mode, input int eb, input int dly, input bit poke);
    logic [1:0]   crit;
    bit           inh;
    logic [127:0] exp_line;
    crit = a[3:2];
    inh  = 1'b0;
    for (int i = 0; i < 4; i++) exp_line[32*i +: 32] = mdata({a[31:4], 2'(i), 2'b00});
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    #1 chk(req_ready, "R8 ready when idle", {127'd0, req_ready}, 128'd1);
    @(posedge clk); @(negedge clk);
    req_valid = poke; req_addr = ~a;
    for (int k = 0; k < 4; k++) begin
      logic [1:0]  w;
      logic [31:0] ea;
      w  = crit + 2'(k);
      ea = {a[31:4], w, 2'b00};
      #1;
      chk(mem_req, "R2 request", {127'd0, mem_req}, 128'd1);
      chk(mem_addr == ea, "R3 wrapped address", {96'd0, mem_addr}, {96'd0, ea});
      if (mode == 2)
        chk(mem_burst == 1'b1, "R9 late inhibit ignored", {127'd0, mem_burst}, 128'd1);
      else
        chk(mem_burst == (k == 0 || !inh), "R4 burst flag", {127'd0, mem_burst}, {127'd0, (k == 0 || !inh)});
      chk(!req_ready, "R8 busy", {127'd0, req_ready}, 128'd0);
      for (int d = 0; d < dly; d++) begin
        @(posedge clk); @(negedge clk); #1;
        chk(mem_req && mem_addr == ea, "R3 hold while waiting", {96'd0, mem_addr}, {96'd0, ea});
      end
      req_valid   = 1'b0;
      mem_err     = (k == eb);
      mem_ack     = (k != eb);
      mem_inhibit = (mode == 1 && k == 0) || (mode == 2 && k > 0);
      mem_rdata   = mdata(ea);
      #1;
      if (k == eb) begin
        chk(fill_err, "R7 error pulse", {127'd0, fill_err}, 128'd1);
        chk(!line_we && !fill_done, "R7 no line write", {127'd0, line_we}, 128'd0);
        @(posedge clk); @(negedge clk);
        mem_err = 1'b0; mem_ack = 1'b0; mem_inhibit = 1'b0;
        #1 chk(!mem_req && req_ready, "R7 back to idle", {126'd0, mem_req, req_ready}, 128'd1);
        return;
      end
      chk(fwd_valid == (k == 0), "R5 forward strobe", {127'd0, fwd_valid}, {127'd0, (k == 0)});
      if (k == 0) chk(fwd_data == mdata(ea), "R5 forward data", {96'd0, fwd_data}, {96'd0, mdata(ea)});
      chk(line_we == (k == 3), "R6 line write timing", {127'd0, line_we}, {127'd0, (k == 3)});
      chk(fill_done == line_we, "R10 done with write", {127'd0, fill_done}, {127'd0, line_we});
      if (k == 3) begin
        chk(line_data == exp_line, "R6 line data", line_data, exp_line);
        chk(line_tag == a[31:10] && line_index == a[9:4], "R6 tag and index",
            {100'd0, line_tag, line_index}, {100'd0, a[31:10], a[9:4]});
        chk(line_valid && line_dirty == 4'd0, "R6 valid clean", {123'd0, line_valid, line_dirty}, 128'h10);
      end
      if (mode == 1 && k == 0) inh = 1'b1;
      @(posedge clk); @(negedge clk);
      mem_ack = 1'b0; mem_inhibit = 1'b0; mem_err = 1'b0;
    end
    #1 chk(!mem_req && req_ready && !line_we, "R8 idle after fill", {125'd0, mem_req, req_ready, line_we}, 128'd2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL R1 watchdog expired actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0;
    mem_ack = 1'b0; mem_inhibit = 1'b0; mem_err = 1'b0; mem_rdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1 chk(req_ready && !mem_req && !line_we, "R1 reset state", {125'd0, req_ready, mem_req, line_we}, 128'h4);

    for (int v = 0; v < 8; v++)
      run_fill(VEC[v].a, int'(VEC[v].mode), int'(VEC[v].eb), int'(VEC[v].dly), 1'b0);

    // R8: a request held high during a fill is ignored
    run_fill(32'hC0DE_1234, 1, 7, 0, 1'b1);
    // back-to-back fills through both paths give the same line
    run_fill(32'h0000_A5A8, 0, 7, 0, 1'b0);
    run_fill(32'h0000_A5A8, 1, 7, 1, 1'b0);

    // R1: reset in the middle of a fill
    @(negedge clk); req_valid = 1'b1; req_addr = 32'h7777_0010;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0; mem_ack = 1'b1; mem_rdata = 32'h1111_2222;
    @(posedge clk); @(negedge clk);
    mem_ack = 1'b0; rst_n = 1'b0;
    #1 chk(!mem_req && req_ready && !line_we, "R1 reset mid-fill", {125'd0, mem_req, req_ready, line_we}, 128'h2);
    @(posedge clk); @(negedge clk); rst_n = 1'b1;
    run_fill(32'h7777_0010, 0, 7, 0, 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule